// File: doc/BRIEF.md
# Handshake-Gated SRAM Access Decoder

This block turns the asynchronous control pins of an SRAM-style memory port into internal read and write operations on a byte array that lives inside the block. The pins are chip enable, output enable, write enable and an active-low store-busy line. A fast system clock samples them. Every access is qualified by the busy line, so a nonvolatile-store sequencer that pulls this line low can keep the array still while it copies it. Each committed write also produces a one-cycle pulse. The sequencer uses this pulse to tell whether the array has changed since its last store.

Each pin, including the address and data inputs, passes through a synchronizer of SYNC_STAGES flops. The block then decodes the synchronized levels. A read enables the data drivers RD_DELAY cycles after the read conditions and the address have settled. The read follows address changes with no toggling of any control pin. A write commits when write enable or chip enable rises, and only if the data was steady for the setup window. The shared data bus is split into pad-side signals (input, output and output enable), ready for a bidirectional pad cell. The full-size part uses ADDR_W = 17 (131,072 bytes). The default of 10 keeps the behavioural array small.

Top module: `sram_gate_decoder`

## Requirements
- R1: While reset is applied and directly after it, `dq_oe` and `wr_done` are 0.
- R2: `dq_oe` is 1 only for a read: chip enable low, output enable low, write enable high and busy high. `dq_out` then carries the byte most recently committed at the read address.
- R3: Say a change of pins makes the read conditions true with a steady address. `dq_oe` then rises after the (SYNC_STAGES+RD_DELAY+1)th rising edge that samples the new pin values (5th with defaults).
- R4: Say the address changes during a read while the control pins do not change. `dq_oe` drops after the (SYNC_STAGES+1)th edge. It returns with the new byte RD_DELAY edges later, without any control pin toggling.
- R5: Any of these drops `dq_oe` after the (SYNC_STAGES+1)th sampling edge: chip enable rising, output enable rising, write enable falling, or busy falling. This holds also when write enable falls while output enable stays low.
- R6: A write opens when chip enable and write enable are both low and busy is high. It commits when write enable or chip enable rises. It stores the data and address of the last sample taken before that rise. `wr_done` is high for exactly one cycle, after the (SYNC_STAGES+1)th edge that samples the rise.
- R7: A write commits only if its last WR_SETUP+1 data samples (3 with defaults) are identical. Otherwise the array keeps its old byte and no `wr_done` pulse appears.
- R8: A write that would open while busy is low is inhibited: the array does not change and no pulse appears. While busy is low, no read enables the drivers.
- R9: A write that opened while busy was high still commits at its end if busy falls before that end.
- R10: The address is ADDR_W bits wide and selects one of 2**ADDR_W independent bytes, including address 0 and the highest address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy_n | input | 1 | Store busy/request line, low blocks access |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data bus, pad input side |
| dq_out | output | DATA_W | Data bus, pad output side |
| dq_oe | output | 1 | Data bus driver enable to the pad |
| wr_done | output | 1 | One-cycle pulse per committed write |

## Verification
Each result has a fixed due time, counted from the first rising edge that sees a pin change. Driver turn-off and the write-done pulse fall due SYNC_STAGES+1 edges later. Driver turn-on falls due SYNC_STAGES+RD_DELAY+1 edges later. The bench drives pins on falling edges and keeps a queue of sampled pin values SYNC_STAGES deep, so its model sees exactly what the decoder sees. It compares the enable, the data and the pulse at every falling edge. Directed checks also count falling edges from a stimulus to the response, so each latency and each setup-window boundary is checked at its exact cycle.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic busy_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic is_read(ctl_t c);
    return !c.ce_n && !c.oe_n && c.we_n && c.busy_n;
  endfunction

  function automatic logic is_write_open(ctl_t c);
    return !c.ce_n && !c.we_n && c.busy_n;
  endfunction

endpackage

// File: rtl/sgd_sync.sv
module sgd_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sgd_read_path.sv
module sgd_read_path #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int RD_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_qual,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);

  localparam int               CNT_W   = (RD_DELAY < 1) ? 1 : $clog2(RD_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RD_DELAY);

  logic              qual_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] dout_q;
  logic              restart;

  // settle counter restarts on any loss of qualification or address move
  always_comb begin
    restart = !rd_qual || !qual_q || (addr != addr_q);
    cnt_d   = cnt_q;
    if (restart)              cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    oe_d = rd_qual && (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      qual_q <= rd_qual;
      addr_q <= addr;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
      if (rd_qual) dout_q <= mem_rdata;
    end
  end

  assign dout = dout_q;
  assign oe   = oe_q;

endmodule

// File: rtl/sgd_write_path.sv
module sgd_write_path #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int WR_SETUP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wr_done
);

  localparam int                STAB_W   = $clog2(WR_SETUP + 2);
  localparam logic [STAB_W-1:0] STAB_MAX = STAB_W'(WR_SETUP);

  logic              open_q, open_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STAB_W-1:0] stab_q, stab_d;
  logic              done_q;
  logic              released, start, commit;

  always_comb begin
    released = ce_n || we_n;
    start    = !ce_n && !we_n && busy_n;
    commit   = open_q && released && (stab_q == STAB_MAX);
    open_d   = open_q ? !released : start;
    stab_d   = '0;
    if (open_d && open_q && (din == data_q)) begin
      stab_d = (stab_q == STAB_MAX) ? stab_q : stab_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      stab_q <= '0;
      done_q <= 1'b0;
    end else begin
      open_q <= open_d;
      addr_q <= addr;
      data_q <= din;
      stab_q <= stab_d;
      done_q <= commit;
    end
  end

  assign mem_we    = commit;
  assign mem_waddr = addr_q;
  assign mem_wdata = data_q;
  assign wr_done   = done_q;

endmodule

// File: rtl/sgd_array.sv
module sgd_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sram_gate_decoder.sv
module sram_gate_decoder
  import sgd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RD_DELAY    = 2,
  parameter int WR_SETUP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              wr_done
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic              rst_core_n;
  ctl_t              ctl_pin, ctl_s;
  logic [BUS_W-1:0]  bus_pin, bus_s;
  logic              s_ce_n, s_oe_n, s_we_n, s_busy_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              rd_qual;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  sgd_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  assign ctl_pin = {ce_n, oe_n, we_n, busy_n};
  assign bus_pin = {addr, dq_in};

  sgd_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_core_n), .d(ctl_pin), .q(ctl_s)
  );

  sgd_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
    .clk(clk), .rst_n(rst_core_n), .d(bus_pin), .q(bus_s)
  );

  assign s_ce_n   = ctl_s.ce_n;
  assign s_oe_n   = ctl_s.oe_n;
  assign s_we_n   = ctl_s.we_n;
  assign s_busy_n = ctl_s.busy_n;
  assign s_addr   = bus_s[BUS_W-1:DATA_W];
  assign s_din    = bus_s[DATA_W-1:0];
  assign rd_qual  = is_read(ctl_s);

  sgd_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_DELAY(RD_DELAY)) u_rd (
    .clk(clk), .rst_n(rst_core_n), .rd_qual(rd_qual), .addr(s_addr),
    .mem_rdata(mem_rdata), .dout(dq_out), .oe(dq_oe)
  );

  sgd_write_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_SETUP(WR_SETUP)) u_wr (
    .clk(clk), .rst_n(rst_core_n), .ce_n(s_ce_n), .we_n(s_we_n), .busy_n(s_busy_n),
    .addr(s_addr), .din(s_din), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .wr_done(wr_done)
  );

  sgd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(s_addr), .rdata(mem_rdata)
  );

endmodule

// File: rtl/sram_gate_decoder_chk.sv
module sram_gate_decoder_chk (
  input logic clk,
  input logic rst_core_n,
  input logic s_ce_n,
  input logic s_oe_n,
  input logic s_we_n,
  input logic s_busy_n,
  input logic dq_oe,
  input logic wr_done
);

  // R2
  rd_qual_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    dq_oe |-> $past(!s_ce_n && !s_oe_n && s_we_n && s_busy_n));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(dq_oe && wr_done));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$past(s_busy_n) |-> !dq_oe);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_done |=> !wr_done);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_done |-> $past(s_we_n || s_ce_n));

endmodule

bind sram_gate_decoder sram_gate_decoder_chk u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .s_ce_n(s_ce_n), .s_oe_n(s_oe_n),
  .s_we_n(s_we_n), .s_busy_n(s_busy_n), .dq_oe(dq_oe), .wr_done(wr_done)
);

// File: tb/sram_gate_decoder_tb.sv
`timescale 1ns/1ps
module sram_gate_decoder_tb;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int S  = 2;
  localparam int D  = 2;
  localparam int SU = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, busy_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe, wr_done;

  always #2 clk = ~clk;

  sram_gate_decoder #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(S), .RD_DELAY(D), .WR_SETUP(SU)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy_n(busy_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .wr_done(wr_done)
  );

  int    n_chk = 0, n_fail = 0;
  bit    checking = 0, finished = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { bit ce, oe, we, busy; int a; int d; } pin_t;
  pin_t      hist[$];
  pin_t      mp, mx, idle_p;
  logic [7:0] mmem [int];
  int  run_len = 0, wr_run = 0, prev_a = 0, last_a = 0, last_d = 0;
  bit  prev_q = 0, in_wr = 0, exp_oe = 0, exp_done = 0, exp_known = 0;
  int  exp_dout = 0;

  initial idle_p = '{1, 1, 1, 1, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < S; i++) hist.push_back(idle_p);
      run_len = 0; prev_q = 0; prev_a = 0; in_wr = 0; exp_oe = 0; exp_done = 0;
    end else begin
      bit q;
      mp = '{ce_n, oe_n, we_n, busy_n, int'(addr), int'(dq_in)};
      hist.push_back(mp);
      mx = hist.pop_front();
      q = !mx.ce && !mx.oe && mx.we && mx.busy;
      if (q && prev_q && mx.a == prev_a) run_len++;
      else if (q) run_len = 1;
      else run_len = 0;
      exp_oe    = (run_len > D);
      exp_known = mmem.exists(mx.a);
      exp_dout  = exp_known ? int'(mmem[mx.a]) : 0;
      prev_q = q; prev_a = mx.a;
      exp_done = 0;
      if (in_wr) begin
        if (mx.ce || mx.we) begin
          if (wr_run >= SU + 1) begin
            mmem[last_a] = 8'(last_d);
            exp_done = 1;
          end
          in_wr = 0;
        end else begin
          wr_run = (mx.d == last_d) ? wr_run + 1 : 1;
          last_a = mx.a; last_d = mx.d;
        end
      end else if (!mx.ce && !mx.we && mx.busy) begin
        in_wr = 1; wr_run = 1; last_a = mx.a; last_d = mx.d;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !finished) begin
      chk(dq_oe == exp_oe, cur_req, "model dq_oe", int'(dq_oe), int'(exp_oe));
      chk(wr_done == exp_done, cur_req, "model wr_done", int'(wr_done), int'(exp_done));
      if (exp_oe && exp_known)
        chk(int'(dq_out) == exp_dout, cur_req, "model dq_out", int'(dq_out), exp_dout);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_idle();
    ce_n = 1; oe_n = 1; we_n = 1; busy_n = 1;
  endtask

  task automatic measure_oe(input bit target, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (dq_oe != target && n < 40);
  endtask

  task automatic count_done(input int cycles, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (wr_done) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic do_write(int a, int d);
    addr = AW'(a); dq_in = DW'(d); ce_n = 0; we_n = 0;
    cyc(4);
    we_n = 1;
    cyc(1);
    ce_n = 1;
    cyc(S + 3);
  endtask

  task automatic read_chk(int a, int expv, string req);
    addr = AW'(a); we_n = 1; busy_n = 1; ce_n = 0; oe_n = 0;
    cyc(S + D + 3);
    chk(dq_oe == 1'b1, req, "read enable", int'(dq_oe), 1);
    chk(int'(dq_out) == expv, req, "read data", int'(dq_out), expv);
    oe_n = 1; ce_n = 1;
    cyc(S + 2);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  // ---------------- scenario ----------------
  initial begin
    int n, cnt, first;
    rst_n = 0; set_idle(); addr = '0; dq_in = '0;
    cyc(5);
    chk(dq_oe == 0, "R1", "oe in reset", int'(dq_oe), 0);
    chk(wr_done == 0, "R1", "done in reset", int'(wr_done), 0);
    rst_n = 1;
    cyc(6);
    chk(dq_oe == 0, "R1", "oe after reset", int'(dq_oe), 0);
    chk(wr_done == 0, "R1", "done after reset", int'(wr_done), 0);
    checking = 1;

    // R6: write commit and pulse timing
    cur_req = "R6";
    addr = AW'(5); dq_in = 8'hA5; ce_n = 0; we_n = 0;
    cyc(5);
    we_n = 1;
    count_done(8, cnt, first);
    chk(cnt == 1, "R6", "pulse count", cnt, 1);
    chk(first == S + 1, "R6", "pulse cycle", first, S + 1);
    ce_n = 1;
    cyc(4);
    do_write(9, 8'h3C);

    // R3: read turn-on latency
    cur_req = "R3";
    addr = AW'(5); ce_n = 0; oe_n = 0;
    measure_oe(1, n);
    chk(n == S + D + 1, "R3", "turn-on cycles", n, S + D + 1);
    // R2: read data
    cur_req = "R2";
    chk(int'(dq_out) == 8'hA5, "R2", "read data", int'(dq_out), 8'hA5);

    // R4: address-follow
    cur_req = "R4";
    addr = AW'(9);
    measure_oe(0, n);
    chk(n == S + 1, "R4", "drop on addr change", n, S + 1);
    measure_oe(1, n);
    chk(n == D, "R4", "return after addr change", n, D);
    chk(int'(dq_out) == 8'h3C, "R4", "new addr data", int'(dq_out), 8'h3C);

    // R5: turn-off rules
    cur_req = "R5";
    oe_n = 1;
    measure_oe(0, n);
    chk(n == S + 1, "R5", "oe rise turn-off", n, S + 1);
    oe_n = 0;
    measure_oe(1, n);
    chk(n == S + D + 1, "R5", "re-enable", n, S + D + 1);
    we_n = 0; dq_in = 8'h5A;
    measure_oe(0, n);
    chk(n == S + 1, "R5", "we fall turn-off with oe low", n, S + 1);
    cyc(2);
    cur_req = "R6";
    we_n = 1;
    cyc(S + D + 3);
    chk(int'(dq_out) == 8'h5A, "R6", "write with oe low", int'(dq_out), 8'h5A);
    set_idle();
    cyc(S + 2);

    // R7: setup window
    cur_req = "R7";
    addr = AW'(9); dq_in = 8'h11; ce_n = 0; we_n = 0;
    cyc(4);
    dq_in = 8'h22;
    cyc(2);
    we_n = 1;
    count_done(8, cnt, first);
    chk(cnt == 0, "R7", "short setup no pulse", cnt, 0);
    ce_n = 1;
    cyc(2);
    read_chk(9, 8'h5A, "R7");
    addr = AW'(9); dq_in = 8'h11; ce_n = 0; we_n = 0;
    cyc(3);
    dq_in = 8'h33;
    cyc(3);
    we_n = 1;
    count_done(8, cnt, first);
    chk(cnt == 1, "R7", "exact setup pulse", cnt, 1);
    ce_n = 1;
    cyc(2);
    read_chk(9, 8'h33, "R7");

    // R8: busy low blocks access
    cur_req = "R8";
    do_write(12, 8'h12);
    busy_n = 0;
    cyc(S + 2);
    addr = AW'(12); dq_in = 8'h77; ce_n = 0; we_n = 0;
    cyc(6);
    we_n = 1;
    count_done(8, cnt, first);
    chk(cnt == 0, "R8", "busy write pulse", cnt, 0);
    ce_n = 1;
    cyc(2);
    ce_n = 0; oe_n = 0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dq_oe) cnt++;
    end
    chk(cnt == 0, "R8", "busy read enable", cnt, 0);
    busy_n = 1;
    measure_oe(1, n);
    chk(n == S + D + 1, "R8", "enable after busy release", n, S + D + 1);
    chk(int'(dq_out) == 8'h12, "R8", "blocked write left byte", int'(dq_out), 8'h12);
    set_idle();
    cyc(S + 2);

    // R9: busy falls mid-write
    cur_req = "R9";
    addr = AW'(20); dq_in = 8'hC3; ce_n = 0; we_n = 0;
    cyc(2);
    busy_n = 0;
    cyc(3);
    we_n = 1;
    count_done(8, cnt, first);
    chk(cnt == 1, "R9", "write survives busy", cnt, 1);
    ce_n = 1; busy_n = 1;
    cyc(S + 2);
    read_chk(20, 8'hC3, "R9");

    // R10: address extremes
    cur_req = "R10";
    do_write(0, 8'h01);
    do_write((1 << AW) - 1, 8'hFE);
    read_chk(0, 8'h01, "R10");
    read_chk((1 << AW) - 1, 8'hFE, "R10");
    read_chk(5, 8'hA5, "R10");

    cyc(4);
    summary();
    $finish;
  end

endmodule